// File: doc/BRIEF.md
# Four-Channel Power Rail Sequencer

A synchronous controller that turns four supply rails on one at a time in a fixed order and turns them off in the opposite order. A single command bit drives both directions. Each rail has an enable output and a rail-good input. A rail is enabled only after the rail below it has reported good and a programmable inter-stage delay has run. On the way down, the next lower rail is released only after the rail above it has reported low and the same delay has run.

While power-up is in progress, a per-stage watchdog is rearmed each time an enable is raised. If the rail does not report good within the programmed limit, the watchdog drops every enable and parks the controller. The watchdog is not used during power-down, and a limit of zero turns it off. A fault-force input also drops every enable and parks the controller. A release pulse returns it to idle. A channel that is not used needs its enable looped back to its rail-good input and nothing else.

Top module: `rail_seq`

## Requirements
- R1: After reset all enables, `done` and `wd_timeout` are low.
- R2: In idle, power-up starts only on a rising `cmd_on`, meaning high at a clock edge after being low at the previous edge. The edge that first samples it high is edge t. `rail_en[0]` rises at edge t+D+1, where D is `dly_count`. D=0 therefore gives a one-cycle delay.
- R3: During power-up, `rail_good[n]` first sampled high at edge t (n<3) makes `rail_en[n+1]` rise at edge t+D+1. Enables rise strictly in index order 0,1,2,3.
- R4: `rail_good[3]` sampled high while it is awaited sets `done` at that same edge, and all four enables are then high.
- R5: With `done` high, `cmd_on` sampled low at edge t clears `rail_en[3]` at edge t.
- R6: During power-down, `rail_good[n]` sampled low at edge t (n>0), while that rail's drop is awaited, clears `rail_en[n-1]` at edge t+D+1. Enables fall strictly from index 3 down to 0.
- R7: `rail_good[0]` sampled low while its drop is awaited clears `done` at that edge and returns the controller to idle.
- R8: A nonzero `wd_limit` is L, and an enable rose at edge k during power-up. If the rail's good bit is not sampled high at any of edges k+1..k+L, then at edge k+L all enables and `done` go low, `wd_timeout` goes high, and the controller stays parked with a later `cmd_on` rise ignored. A good bit sampled at edge k+L itself wins over the expiry.
- R9: With `wd_limit` = 0 a rail may take any time to report good without a fault.
- R10: No watchdog runs in power-down. A slow rail drop never raises `wd_timeout` or parks the controller.
- R11: While `fault_force` is high all enables are low in that same cycle. From the next edge the controller is parked with `done` low. It leaves the parked state only at an edge that samples `fault_release` high and `fault_force` low. It then goes to idle with `wd_timeout` cleared and needs a new `cmd_on` rise to start.
- R12: `cmd_on` going low during power-up does not stop it. Power-down begins only after `done` is set.
- R13: A channel whose enable is looped straight back to its rail-good input sequences like any other rail with no extra handling.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_on | input | 1 | Debounced on/off command |
| rail_good | input | 4 | Rail-good bit per rail, index 0 first up |
| fault_force | input | 1 | Forces all enables off and parks the controller |
| fault_release | input | 1 | Leaves the parked state |
| dly_count | input | 8 | Inter-stage delay; D gives D+1 cycles |
| wd_limit | input | 8 | Power-good watchdog limit in cycles; 0 disables |
| rail_en | output | 4 | Rail enables |
| done | output | 1 | High from power-up completion to power-down completion |
| wd_timeout | output | 1 | High while parked after a watchdog expiry |

## Verification
Every result here lands at a fixed edge after its trigger. An enable rises or falls D+1 edges after the previous rail's good bit is sampled. `done` and the first power-down release change at the very edge that samples their trigger. A watchdog expiry acts L edges after the enable, and `fault_force` acts on the enables within the same cycle. The bench drives inputs on falling edges and holds a behavioural model that steps once per rising edge. One time unit after each falling edge it compares enables, `done` and `wd_timeout` with the model, so every latency above is checked on the exact edge. Named spot checks confirm the edge counts of R2 and R5 and the parked state directly.

// File: rtl/rail_seq_pkg.sv
package rail_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_UP_DLY,
    ST_UP_WAIT,
    ST_ON,
    ST_DN_WAIT,
    ST_DN_DLY,
    ST_PARK
  } seq_state_t;

  // Inter-stage delay ends when the running count equals the programmed value.
  function automatic logic delay_reached(input logic [31:0] cnt, input logic [31:0] lim);
    return cnt == lim;
  endfunction

  // Watchdog expires on the lim-th waiting cycle; lim of zero never expires.
  function automatic logic watchdog_expired(input logic [31:0] cnt, input logic [31:0] lim);
    return (lim != 32'd0) && (cnt + 32'd1 == lim);
  endfunction

endpackage

// File: rtl/seq_delay_timer.sv
module seq_delay_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic [W-1:0] limit,
  output logic         hit
);
  import rail_seq_pkg::*;

  logic [W-1:0] cnt;

  assign hit = run && delay_reached(32'(cnt), 32'(limit));

  always_ff @(posedge clk) begin
    if (!rst_n)          cnt <= '0;
    else if (!run || hit) cnt <= '0;
    else                 cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/seq_pg_watchdog.sv
module seq_pg_watchdog #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic [W-1:0] limit,
  output logic         expire
);
  import rail_seq_pkg::*;

  logic [W-1:0] cnt;

  assign expire = run && watchdog_expired(32'(cnt), 32'(limit));

  always_ff @(posedge clk) begin
    if (!rst_n)             cnt <= '0;
    else if (!run || expire) cnt <= '0;
    else                    cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/seq_enable_bank.sv
module seq_enable_bank #(
  parameter int N     = 4,
  parameter int IDX_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] sel,
  input  logic             set_en,
  input  logic             clr_en,
  input  logic             kill,
  input  logic             force_off,
  output logic [N-1:0]     en_out
);
  logic [N-1:0] en_q;

  for (genvar g = 0; g < N; g++) begin : g_rail
    logic picked;
    assign picked = (sel == IDX_W'(g));
    always_ff @(posedge clk) begin
      if (!rst_n)                en_q[g] <= 1'b0;
      else if (kill)             en_q[g] <= 1'b0;
      else if (set_en && picked) en_q[g] <= 1'b1;
      else if (clr_en && picked) en_q[g] <= 1'b0;
    end
    assign en_out[g] = en_q[g] && !force_off;
  end
endmodule

// File: rtl/rail_seq.sv
module rail_seq #(
  parameter int N_RAILS = 4,
  parameter int DLY_W   = 8,
  parameter int WD_W    = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cmd_on,
  input  logic [N_RAILS-1:0] rail_good,
  input  logic               fault_force,
  input  logic               fault_release,
  input  logic [DLY_W-1:0]   dly_count,
  input  logic [WD_W-1:0]    wd_limit,
  output logic [N_RAILS-1:0] rail_en,
  output logic               done,
  output logic               wd_timeout
);
  import rail_seq_pkg::*;

  localparam int IDX_W = (N_RAILS > 1) ? $clog2(N_RAILS) : 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(N_RAILS - 1);

  seq_state_t       state;
  logic [IDX_W-1:0] idx;
  logic             cmd_q;
  logic             done_q;
  logic             wdto_q;

  // Named internal events
  logic             start_req;
  logic             stage_good;
  logic             stage_low;
  logic             dly_run;
  logic             dly_hit;
  logic             wd_run;
  logic             wd_expire;
  logic             wd_kill;
  logic             en_set;
  logic             en_clr;
  logic             en_kill;
  logic [IDX_W-1:0] en_sel;

  always_comb begin
    start_req  = (state == ST_IDLE) && cmd_on && !cmd_q;
    stage_good = rail_good[idx];
    stage_low  = !rail_good[idx];
    dly_run    = (state == ST_UP_DLY) || (state == ST_DN_DLY);
    wd_run     = (state == ST_UP_WAIT);
    wd_kill    = wd_run && wd_expire && !stage_good;
    en_set     = (state == ST_UP_DLY) && dly_hit;
    en_clr     = ((state == ST_ON) && !cmd_on) || ((state == ST_DN_DLY) && dly_hit);
    en_kill    = fault_force || wd_kill;
    en_sel     = (state == ST_DN_DLY) ? idx - 1'b1 : idx;
  end

  seq_delay_timer #(.W(DLY_W)) u_dly (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (dly_run),
    .limit (dly_count),
    .hit   (dly_hit)
  );

  seq_pg_watchdog #(.W(WD_W)) u_wd (
    .clk    (clk),
    .rst_n  (rst_n),
    .run    (wd_run),
    .limit  (wd_limit),
    .expire (wd_expire)
  );

  seq_enable_bank #(.N(N_RAILS), .IDX_W(IDX_W)) u_bank (
    .clk       (clk),
    .rst_n     (rst_n),
    .sel       (en_sel),
    .set_en    (en_set),
    .clr_en    (en_clr),
    .kill      (en_kill),
    .force_off (fault_force),
    .en_out    (rail_en)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      idx    <= '0;
      cmd_q  <= 1'b0;
      done_q <= 1'b0;
      wdto_q <= 1'b0;
    end else begin
      cmd_q <= cmd_on;
      if (fault_force) begin
        state  <= ST_PARK;
        done_q <= 1'b0;
      end else begin
        case (state)
          ST_IDLE: begin
            if (start_req) begin
              state <= ST_UP_DLY;
              idx   <= '0;
            end
          end
          ST_UP_DLY: begin
            if (dly_hit) state <= ST_UP_WAIT;
          end
          ST_UP_WAIT: begin
            if (stage_good) begin
              if (idx == LAST_IDX) begin
                done_q <= 1'b1;
                state  <= ST_ON;
              end else begin
                idx   <= idx + 1'b1;
                state <= ST_UP_DLY;
              end
            end else if (wd_expire) begin
              state  <= ST_PARK;
              done_q <= 1'b0;
              wdto_q <= 1'b1;
            end
          end
          ST_ON: begin
            if (!cmd_on) state <= ST_DN_WAIT;
          end
          ST_DN_WAIT: begin
            if (stage_low) begin
              if (idx == '0) begin
                done_q <= 1'b0;
                state  <= ST_IDLE;
              end else begin
                state <= ST_DN_DLY;
              end
            end
          end
          ST_DN_DLY: begin
            if (dly_hit) begin
              idx   <= idx - 1'b1;
              state <= ST_DN_WAIT;
            end
          end
          ST_PARK: begin
            if (fault_release) begin
              state  <= ST_IDLE;
              wdto_q <= 1'b0;
            end
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

  assign done       = done_q;
  assign wd_timeout = wdto_q;

endmodule

// File: rtl/rail_seq_chk.sv
module rail_seq_chk #(
  parameter int N_RAILS = 4,
  parameter int WD_W    = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic [N_RAILS-1:0] rail_en,
  input logic [N_RAILS-1:0] rail_good,
  input logic               done,
  input logic               wd_timeout,
  input logic               fault_force,
  input logic [WD_W-1:0]    wd_limit
);

  // R11: a forced fault leaves every enable and done low on the next edge
  p_force_clears_r11: assert property (@(posedge clk) disable iff (!rst_n)
    fault_force |=> (rail_en == '0 && !done));

  // R2: the first enable rises only from an all-off state
  p_first_from_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rail_en[0]) |-> ($past(rail_en) == '0));

  for (genvar i = 1; i < N_RAILS; i++) begin : g_up
    // R3: a rail is enabled only above an enabled, good rail
    p_up_order_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rail_en[i]) |-> (rail_en[i-1] && $past(rail_good[i-1])));
  end

  for (genvar i = 0; i < N_RAILS - 1; i++) begin : g_dn
    // R6: a rail is released only when every rail above it is already off
    p_down_order_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(rail_en[i]) |-> ((rail_en >> (i + 1)) == '0));
  end

  // R4: done rises only with all rails enabled
  p_done_all_on_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(done) && !fault_force) |-> (&rail_en));

  // R8: a watchdog expiry comes with every enable and done low
  p_wd_parks_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wd_timeout) |-> (rail_en == '0 && !done));

  // R9: a zero limit never produces an expiry
  p_wd_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wd_timeout) |-> ($past(wd_limit) != '0));

endmodule

bind rail_seq rail_seq_chk #(.N_RAILS(N_RAILS), .WD_W(WD_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .rail_en     (rail_en),
  .rail_good   (rail_good),
  .done        (done),
  .wd_timeout  (wd_timeout),
  .fault_force (fault_force),
  .wd_limit    (wd_limit)
);

// File: tb/rail_seq_tb_top.sv
`timescale 1ns/1ps
module rail_seq_tb_top;
  localparam int NEVER = 1000000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmd_on = 1'b0;
  logic [3:0] rg = 4'b0;
  logic       fault_force = 1'b0;
  logic       fault_release = 1'b0;
  logic [7:0] dly = 8'd3;
  logic [7:0] wdl = 8'd20;
  logic [3:0] rail_en;
  logic       done;
  logic       wd_timeout;

  always #2 clk = ~clk;

  rail_seq dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_on(cmd_on), .rail_good(rg),
    .fault_force(fault_force), .fault_release(fault_release),
    .dly_count(dly), .wd_limit(wdl),
    .rail_en(rail_en), .done(done), .wd_timeout(wd_timeout)
  );

  int n_chk = 0;
  int n_fail = 0;
  string cur_req = "R1";
  int cyc = 0;

  int lat_up[4];
  int lat_dn[4];
  int up_c[4];
  int dn_c[4];

  // Behavioural reference: phase 0 idle, 1 rising delay, 2 awaiting good,
  // 3 all on, 4 awaiting drop, 5 falling delay, 6 parked
  int         ph = 0;
  int         k = 0;
  int         left = 0;
  int         wd = 0;
  logic [3:0] m_en = 4'b0;
  logic       m_done = 1'b0;
  logic       m_wto = 1'b0;
  logic       m_prev = 1'b0;

  always @(posedge clk) begin
    if (!rst_n) begin
      ph = 0; k = 0; left = 0; wd = 0;
      m_en = 4'b0; m_done = 1'b0; m_wto = 1'b0; m_prev = 1'b0;
    end else begin
      if (fault_force) begin
        ph = 6; m_en = 4'b0; m_done = 1'b0;
      end else begin
        case (ph)
          0: if (cmd_on && !m_prev) begin ph = 1; k = 0; left = int'(dly); end
          1: if (left == 0) begin m_en[k] = 1'b1; ph = 2; wd = 0; end else left--;
          2: if (rg[k]) begin
               if (k == 3) begin m_done = 1'b1; ph = 3; end
               else begin k++; ph = 1; left = int'(dly); end
             end else if (wdl != 0 && wd + 1 >= int'(wdl)) begin
               ph = 6; m_en = 4'b0; m_done = 1'b0; m_wto = 1'b1;
             end else wd++;
          3: if (!cmd_on) begin m_en[3] = 1'b0; k = 3; ph = 4; end
          4: if (!rg[k]) begin
               if (k == 0) begin m_done = 1'b0; ph = 0; end
               else begin ph = 5; left = int'(dly); end
             end
          5: if (left == 0) begin k--; m_en[k] = 1'b0; ph = 4; end else left--;
          6: if (fault_release) begin ph = 0; m_wto = 1'b0; end
          default: ph = 0;
        endcase
      end
      m_prev = cmd_on;
    end
  end

  // Rail plant: follows the reference enables with per-rail latencies
  always @(negedge clk) begin
    for (int i = 0; i < 4; i++) begin
      if (m_en[i]) begin
        dn_c[i] = 0;
        if (!rg[i]) begin
          if (up_c[i] >= lat_up[i]) rg[i] = 1'b1; else up_c[i]++;
        end
      end else begin
        up_c[i] = 0;
        if (rg[i]) begin
          if (dn_c[i] >= lat_dn[i]) rg[i] = 1'b0; else dn_c[i]++;
        end
      end
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // Cycle-by-cycle comparison against the reference
  always @(negedge clk) begin
    #1;
    if (rst_n) begin
      chk({cur_req, " rail_en"}, int'(rail_en), int'(m_en & ~{4{fault_force}}));
      chk({cur_req, " done"}, int'(done), int'(m_done));
      chk({cur_req, " wd_timeout"}, int'(wd_timeout), int'(m_wto));
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  task automatic run(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic lats(input int u0, u1, u2, u3, d0, d1, d2, d3);
    lat_up[0] = u0; lat_up[1] = u1; lat_up[2] = u2; lat_up[3] = u3;
    lat_dn[0] = d0; lat_dn[1] = d1; lat_dn[2] = d2; lat_dn[3] = d3;
  endtask

  initial begin
    for (int i = 0; i < 4; i++) begin up_c[i] = 0; dn_c[i] = 0; end
    lats(2, 5, 1, 4, 3, 1, 6, 2);
    run(4);
    #1;
    chk("R1 rail_en", int'(rail_en), 0);
    chk("R1 done", int'(done), 0);
    chk("R1 wd_timeout", int'(wd_timeout), 0);
    @(negedge clk); rst_n = 1'b1;
    run(3);

    // R2/R3/R4 power-up with D=3
    cur_req = "R3";
    cmd_on = 1'b1;
    run(4); #1; chk("R2 en0 before D+1", int'(rail_en[0]), 0);
    run(1); #1; chk("R2 en0 at D+1", int'(rail_en[0]), 1);
    run(80); #1;
    chk("R4 done", int'(done), 1);
    chk("R4 all on", int'(rail_en), 15);
    // R5/R6/R7 power-down
    cur_req = "R5";
    cmd_on = 1'b0;
    run(1); #1; chk("R5 en3 first off", int'(rail_en), 7);
    cur_req = "R6";
    run(100); #1;
    chk("R7 done low", int'(done), 0);
    chk("R6 all off", int'(rail_en), 0);

    // R13 loopback rails, minimum delay
    cur_req = "R13";
    dly = 8'd0;
    lats(0, 0, 0, 0, 0, 0, 0, 0);
    cmd_on = 1'b1;
    run(1); #1; chk("R2 D0 before", int'(rail_en[0]), 0);
    run(1); #1; chk("R2 D0 one cycle", int'(rail_en[0]), 1);
    run(30); #1; chk("R13 done", int'(done), 1);
    cmd_on = 1'b0;
    run(30); #1; chk("R13 down", int'(rail_en), 0);

    // R8 watchdog expiry on rail 2
    cur_req = "R8";
    dly = 8'd1; wdl = 8'd6;
    lats(1, 1, NEVER, 1, 1, 1, 1, 1);
    cmd_on = 1'b1;
    run(60); #1;
    chk("R8 wd_timeout", int'(wd_timeout), 1);
    chk("R8 enables off", int'(rail_en), 0);
    cmd_on = 1'b0; run(2); cmd_on = 1'b1; run(6); #1;
    chk("R8 parked ignores cmd", int'(rail_en), 0);
    cur_req = "R11";
    fault_release = 1'b1; run(1); fault_release = 1'b0; run(1); #1;
    chk("R11 release clears wd_timeout", int'(wd_timeout), 0);
    run(10); #1;
    chk("R11 no start without rise", int'(rail_en), 0);
    cmd_on = 1'b0; run(3);

    // R9 watchdog disabled, slow rail 1
    cur_req = "R9";
    wdl = 8'd0;
    lats(1, 40, 1, 1, 1, 1, 1, 1);
    cmd_on = 1'b1;
    run(90); #1;
    chk("R9 done", int'(done), 1);
    chk("R9 no timeout", int'(wd_timeout), 0);
    cmd_on = 1'b0;
    run(40);

    // R10 slow drops with a tight watchdog
    cur_req = "R10";
    wdl = 8'd3;
    lats(1, 1, 1, 1, 40, 40, 40, 40);
    cmd_on = 1'b1;
    run(40); #1; chk("R10 up done", int'(done), 1);
    cmd_on = 1'b0;
    run(220); #1;
    chk("R10 down done", int'(done), 0);
    chk("R10 no timeout", int'(wd_timeout), 0);

    // R11 forced fault mid power-up
    cur_req = "R11";
    wdl = 8'd20; dly = 8'd2;
    lats(3, 3, 3, 3, 1, 1, 1, 1);
    cmd_on = 1'b1;
    run(14);
    fault_force = 1'b1; #1;
    chk("R11 same-cycle off", int'(rail_en), 0);
    run(5); fault_force = 1'b0;
    run(5); #1;
    chk("R11 parked", int'(rail_en), 0);
    chk("R11 done low", int'(done), 0);
    fault_release = 1'b1; run(1); fault_release = 1'b0;
    run(10); #1;
    chk("R11 idle after release", int'(rail_en), 0);
    cmd_on = 1'b0; run(3);

    // R12 command drops during power-up
    cur_req = "R12";
    cmd_on = 1'b1;
    run(6);
    cmd_on = 1'b0;
    run(5); #1;
    chk("R12 still rising", int'(rail_en != 0), 1);
    run(120); #1;
    chk("R12 completed then down", int'(rail_en), 0);
    chk("R12 done cleared", int'(done), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule